// File: doc/BRIEF.md
# Self-Forwarding Add/Subtract Unit

This block is a two-stage add/subtract execution unit that can take its own most recent result as an operand on the very next operation, with no bubble. Feedback reaches only one fixed adder input. The other input has no feedback multiplexer. A steering stage in front of the adder decodes the operation and the forwarding request into a small set of controls:

- operand swap
- inversion of either adder input
- carry-in value
- feedback select
- a zero override

These controls make the correct sum appear even when the forwarded value belongs on the input that cannot receive it.

Two cases cannot be routed this way:

- **Subtracting the forwarded value from itself.** This is rewritten as a constant-zero result.
- **Adding the forwarded value to itself.** This is refused. The unit raises a reject signal in the same cycle and drops the operation, so the issuer must replay it later with the value from the register file.

The unit also produces zero, overflow, negative and carry flags. The zero flag is formed from a low slice of the sum, which is resolved early, and the high slice.

The issuer presents one operation per cycle with `in_valid`. The result and flags appear two clock edges later, qualified by `out_valid`. A forward request means "use the result of the most recently accepted operation". Rejected operations are not accepted and produce no output.

Top module: `fwd_adder`

## Requirements
- R1: After reset `out_valid`, `out_result` and all four flags are 0, and the forwarded value is 0.
- R2: An operation accepted at a clock edge appears on the outputs after the following edge with `out_valid`=1, giving A+B (`in_sub`=0) or A−B (`in_sub`=1) modulo 2^W, where A and B are `in_opa` and `in_opb`.
- R3: With `in_fwd_b`=1 (and `in_fwd_a`=0), B is replaced by the last accepted result and `in_opb` is ignored, for both add and subtract, even when the producer was issued in the previous cycle.
- R4: With `in_fwd_a`=1 (and `in_fwd_b`=0), A is replaced by the last accepted result and `in_opa` is ignored, for both add and subtract, with operand order kept (result − B for subtract).
- R5: A subtract with both forward bits set produces result 0 with Z=1, N=0, V=0, C=1.
- R6: An add with both forward bits set and `in_valid`=1 drives `in_reject`=1 combinationally in that cycle, produces no output, and leaves the forwarded value unchanged. In every other case `in_reject`=0.
- R7: Result and flags hold while no operation completes. The forwarded value stays the last completed result across idle cycles.
- R8: C is the carry out of A+B for add and of A+~B+1 for subtract.
- R9: V is 1 exactly when A and the second adder term (B for add, ~B for subtract) have equal sign bits and the result sign differs from them.
- R10: N equals result bit W−1, and Z is 1 exactly when the full W-bit result is 0, including results whose low ZLO bits are zero but whose upper bits are not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issued this cycle |
| in_sub | input | 1 | 1 = subtract, 0 = add |
| in_fwd_a | input | 1 | First operand is the last result |
| in_fwd_b | input | 1 | Second operand is the last result |
| in_opa | input | W | First operand from register file |
| in_opb | input | W | Second operand from register file |
| in_reject | output | 1 | Operation refused (self-add of forwarded value) |
| out_valid | output | 1 | Result and flags updated this cycle |
| out_result | output | W | Sum or difference |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Signed overflow flag |
| out_n | output | 1 | Negative flag |
| out_c | output | 1 | Carry-out flag |

## Verification
Each operand pair in a near-exhaustive sweep first runs unforwarded as add or subtract. This separates a wrong base sum or wrong flags from a steering fault. A forwarded follower then comes straight after it, in one of six modes: add or subtract with the forward on either side, subtract of the result from itself, or the refused self-add followed by its replay from the register file. A wrong swap, inversion or carry-in changes the sum or the carry only in its own mode. The sweep includes the sign boundaries 0x7F/0x80 and 0xFF, and low-slice-zero values such as 0x20 and 0xE0, so overflow and a zero flag built only from the low slice are exposed. Idle gaps show whether the forwarded value survives cycles with no operation.

// File: rtl/fwd_adder_pkg.sv
package fwd_adder_pkg;

  // Steering controls handed from the decode stage to the adder stage.
  typedef struct packed {
    logic swap;      // non-feedback input takes opb instead of opa
    logic inv_g;     // invert the non-feedback adder input
    logic inv_f;     // invert the feedback-capable adder input
    logic cin;       // adder carry-in (forced 0 or 1)
    logic sel_fb;    // feedback-capable input takes the previous result
    logic zero_set;  // result replaced by constant zero
  } steer_t;

endpackage

// File: rtl/fwd_adder_steer.sv
module fwd_adder_steer
  import fwd_adder_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_sub,
  input  logic         in_fwd_a,
  input  logic         in_fwd_b,
  input  logic [W-1:0] in_opa,
  input  logic [W-1:0] in_opb,
  output logic         reject,
  output logic         dec_vld,
  output logic [W-1:0] dec_opa,
  output logic [W-1:0] dec_opb,
  output steer_t       dec_st
);

  steer_t st_d;
  logic   refuse;
  logic   accept;

  // Next-state: steering decode of operation and forwarding request.
  always_comb begin
    st_d   = '0;
    refuse = 1'b0;
    unique case ({in_sub, in_fwd_a, in_fwd_b})
      3'b000: ;
      3'b001: st_d.sel_fb = 1'b1;
      3'b010: begin st_d.swap = 1'b1; st_d.sel_fb = 1'b1; end
      3'b011: refuse = 1'b1;
      3'b100: begin st_d.inv_f = 1'b1; st_d.cin = 1'b1; end
      3'b101: begin st_d.sel_fb = 1'b1; st_d.inv_f = 1'b1; st_d.cin = 1'b1; end
      3'b110: begin
        st_d.swap   = 1'b1;
        st_d.sel_fb = 1'b1;
        st_d.inv_g  = 1'b1;
        st_d.cin    = 1'b1;
      end
      default: st_d.zero_set = 1'b1;
    endcase
  end

  assign reject = in_valid & refuse;
  assign accept = in_valid & ~refuse;

  // Register process with explicit clock enable on the payload.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld <= 1'b0;
      dec_opa <= '0;
      dec_opb <= '0;
      dec_st  <= '0;
    end else begin
      dec_vld <= accept;
      if (accept) begin
        dec_opa <= in_opa;
        dec_opb <= in_opb;
        dec_st  <= st_d;
      end
    end
  end

  // R5: self-subtract of the forwarded value becomes a zero override
  a_r5_zero_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sub && in_fwd_a && in_fwd_b) |=> (dec_vld && dec_st.zero_set));

  // R4/R3: a subtract never inverts both adder inputs
  a_r4_single_invert: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> !(dec_st.inv_f && dec_st.inv_g));

endmodule

// File: rtl/fwd_adder_core.sv
module fwd_adder_core #(
  parameter int W   = 32,
  parameter int ZLO = 20
) (
  input  logic [W-1:0] f,
  input  logic [W-1:0] g,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         co,
  output logic         ovf,
  output logic         neg,
  output logic         zero
);

  localparam int HW = W - ZLO;

  logic [ZLO:0] lo;
  logic [HW:0]  hi;
  logic         zero_lo;

  // Low slice resolves first; its zero test is ready before the high slice.
  always_comb begin
    lo      = {1'b0, f[ZLO-1:0]} + {1'b0, g[ZLO-1:0]} + {{ZLO{1'b0}}, cin};
    zero_lo = ~|lo[ZLO-1:0];
    hi      = {1'b0, f[W-1:ZLO]} + {1'b0, g[W-1:ZLO]} + {{HW{1'b0}}, lo[ZLO]};
    sum     = {hi[HW-1:0], lo[ZLO-1:0]};
    co      = hi[HW];
    neg     = hi[HW-1];
    zero    = zero_lo & ~|hi[HW-1:0];
    ovf     = (f[W-1] ~^ g[W-1]) & (hi[HW-1] ^ f[W-1]);
  end

endmodule

// File: rtl/fwd_adder.sv
module fwd_adder
  import fwd_adder_pkg::*;
#(
  parameter int W   = 32,
  parameter int ZLO = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_sub,
  input  logic         in_fwd_a,
  input  logic         in_fwd_b,
  input  logic [W-1:0] in_opa,
  input  logic [W-1:0] in_opb,
  output logic         in_reject,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_z,
  output logic         out_v,
  output logic         out_n,
  output logic         out_c
);

  logic         dec_vld;
  logic [W-1:0] dec_opa;
  logic [W-1:0] dec_opb;
  steer_t       dec_st;

  logic [W-1:0] res_q;
  logic [W-1:0] f_pre, g_pre, f_in, g_in, sum;
  logic         co, ovf, neg, zero;
  logic [W-1:0] res_d;
  logic         z_d, v_d, n_d, c_d;
  logic         z_q, v_q, n_q, c_q, vld_q;

  fwd_adder_steer #(.W(W)) u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sub   (in_sub),
    .in_fwd_a (in_fwd_a),
    .in_fwd_b (in_fwd_b),
    .in_opa   (in_opa),
    .in_opb   (in_opb),
    .reject   (in_reject),
    .dec_vld  (dec_vld),
    .dec_opa  (dec_opa),
    .dec_opb  (dec_opb),
    .dec_st   (dec_st)
  );

  // Only the feedback-capable input f sees the previous result.
  always_comb begin
    f_pre = dec_st.sel_fb ? res_q : (dec_st.swap ? dec_opa : dec_opb);
    g_pre = dec_st.swap ? dec_opb : dec_opa;
    f_in  = dec_st.inv_f ? ~f_pre : f_pre;
    g_in  = dec_st.inv_g ? ~g_pre : g_pre;
  end

  fwd_adder_core #(.W(W), .ZLO(ZLO)) u_core (
    .f    (f_in),
    .g    (g_in),
    .cin  (dec_st.cin),
    .sum  (sum),
    .co   (co),
    .ovf  (ovf),
    .neg  (neg),
    .zero (zero)
  );

  // Next-state for the result stage.
  always_comb begin
    if (dec_st.zero_set) begin
      res_d = '0;
      z_d   = 1'b1;
      v_d   = 1'b0;
      n_d   = 1'b0;
      c_d   = 1'b1;
    end else begin
      res_d = sum;
      z_d   = zero;
      v_d   = ovf;
      n_d   = neg;
      c_d   = co;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      z_q   <= 1'b0;
      v_q   <= 1'b0;
      n_q   <= 1'b0;
      c_q   <= 1'b0;
    end else begin
      vld_q <= dec_vld;
      if (dec_vld) begin
        res_q <= res_d;
        z_q   <= z_d;
        v_q   <= v_d;
        n_q   <= n_d;
        c_q   <= c_d;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_z      = z_q;
  assign out_v      = v_q;
  assign out_n      = n_q;
  assign out_c      = c_q;

  // R6: a refused operation never completes
  a_r6_reject_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    in_reject |=> ##1 !out_valid);

  // R7: no completion means result held
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result));

  // R10: zero flag built from split slices matches the whole result
  a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_z == (out_result == '0)));

  // R10: negative flag is the result sign
  a_r10_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_n == out_result[W-1]));

  // R5: zero override yields clean flags
  a_r5_zero_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dec_vld && dec_st.zero_set) |-> (out_result == '0 && out_c && !out_v));

endmodule

// File: tb/fwd_adder_bench.sv
module fwd_adder_bench;

  localparam int W   = 8;
  localparam int ZLO = 5;
  localparam int NV  = 48;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_sub = 1'b0;
  logic         in_fwd_a = 1'b0;
  logic         in_fwd_b = 1'b0;
  logic [W-1:0] in_opa = '0;
  logic [W-1:0] in_opb = '0;
  logic         in_reject, out_valid, out_z, out_v, out_n, out_c;
  logic [W-1:0] out_result;

  always #4 clk = ~clk;

  fwd_adder #(.W(W), .ZLO(ZLO)) u_fwd_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
    .in_fwd_a(in_fwd_a), .in_fwd_b(in_fwd_b), .in_opa(in_opa), .in_opb(in_opb),
    .in_reject(in_reject), .out_valid(out_valid), .out_result(out_result),
    .out_z(out_z), .out_v(out_v), .out_n(out_n), .out_c(out_c)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic         running = 1'b0;
  logic [W-1:0] last = '0;       // model of the forwarded value
  logic [W-1:0] seen_last = '0;  // last expected output value

  // expected-result ring: {c,v,n,z,result}
  logic [W+3:0] exp_q [0:15];
  string        exp_tag [0:15];
  logic [3:0]   wp = '0;
  logic [3:0]   rp = '0;
  int           pend = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W+3:0] model(input logic sub, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0]   s;
    logic [W-1:0] bb;
    logic         v;
    bb = sub ? ~b : b;
    s  = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, sub};
    v  = (a[W-1] == bb[W-1]) && (s[W-1] != a[W-1]);
    return {s[W], v, s[W-1], (s[W-1:0] == '0), s[W-1:0]};
  endfunction

  function automatic logic [W-1:0] val(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h7F;
      2: return 8'h80;
      3: return 8'hFF;
      4: return 8'h20;
      5: return 8'hE0;
      6: return 8'h01;
      default: return W'((i * 53 + 7) % 256);
    endcase
  endfunction

  task automatic issue(input logic sub, input logic fa, input logic fb,
                       input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic [W-1:0] ea, eb;
    @(negedge clk);
    in_valid = 1'b1; in_sub = sub; in_fwd_a = fa; in_fwd_b = fb;
    in_opa = a; in_opb = b;
    #1;
    if (!sub && fa && fb) begin
      check(in_reject === 1'b1, "R6", longint'(in_reject), 1);
    end else begin
      check(in_reject === 1'b0, "R6", longint'(in_reject), 0);
      ea = fa ? last : a;
      eb = fb ? last : b;
      exp_q[wp]   = model(sub, ea, eb);
      exp_tag[wp] = tag;
      last = exp_q[wp][W-1:0];
      wp = wp + 4'd1;
      pend++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Output checker, sampled away from the active edge.
  always @(negedge clk) begin
    if (running) begin
      if (out_valid) begin
        if (pend == 0) begin
          check(1'b0, "R6", 1, 0);
        end else begin
          check(out_result === exp_q[rp][W-1:0], exp_tag[rp], longint'(out_result), longint'(exp_q[rp][W-1:0]));
          check(out_c === exp_q[rp][W+3], "R8", longint'(out_c), longint'(exp_q[rp][W+3]));
          check(out_v === exp_q[rp][W+2], "R9", longint'(out_v), longint'(exp_q[rp][W+2]));
          check(out_n === exp_q[rp][W+1], "R10", longint'(out_n), longint'(exp_q[rp][W+1]));
          check(out_z === exp_q[rp][W], "R10", longint'(out_z), longint'(exp_q[rp][W]));
          seen_last = exp_q[rp][W-1:0];
          rp = rp + 4'd1;
          pend--;
        end
      end else begin
        check(out_result === seen_last, "R7", longint'(out_result), longint'(seen_last));
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [W-1:0] a, b, c;
    int mode;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    check(out_result === '0, "R1", longint'(out_result), 0);
    check({out_z, out_v, out_n, out_c} === 4'b0, "R1", longint'({out_z, out_v, out_n, out_c}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    // R1: first forward after reset sees zero
    issue(1'b0, 1'b0, 1'b1, 8'h33, 8'hAA, "R1");
    idle(3);
    for (int i = 0; i < NV; i++) begin
      for (int j = 0; j < NV; j++) begin
        a = val(i);
        b = val(j);
        c = val((i + j * 5) % NV);
        issue(1'((i + j) % 2), 1'b0, 1'b0, a, b, "R2");
        mode = (i * 7 + j) % 6;
        case (mode)
          0: issue(1'b0, 1'b0, 1'b1, c, 8'hA5, "R3");
          1: issue(1'b0, 1'b1, 1'b0, 8'h5A, c, "R4");
          2: issue(1'b1, 1'b0, 1'b1, c, 8'hA5, "R3");
          3: issue(1'b1, 1'b1, 1'b0, 8'h5A, c, "R4");
          4: issue(1'b1, 1'b1, 1'b1, c, c, "R5");
          default: begin
            issue(1'b0, 1'b1, 1'b1, c, c, "R6");
            issue(1'b0, 1'b0, 1'b0, last, last, "R6");
          end
        endcase
        if ((i + j) % 7 == 0) begin
          idle(3);
          // R7: forwarded value survives idle gap
          issue(1'b1, 1'b0, 1'b1, c, 8'h00, "R7");
        end
      end
    end
    idle(5);
    check(pend == 0, "R2", longint'(pend), 0);
    finish_run();
  end

endmodule